// File: doc/BRIEF.md
# Codec command sequencer

The sequencer controls a serial audio codec's reset line and the register traffic that travels in the command slots of each outgoing frame. After system reset it holds the codec in reset for a fixed number of clock cycles and then releases it. While the codec does not report ready, every frame it supplies to the frame generator is all zeros. Once the codec is ready, it sends a built-in list of register writes, one per frame. It then serves single register write and read requests from a host.

Each command is presented as a 16-bit tag and two 20-bit slots. The frame generator loads them at every frame boundary. A read is tracked against the status slots that the receive decoder reports. It ends either when a status frame returns the requested address, or with an error flag after a bounded number of frames with no reply. Frame outputs change on the clock edge at which `frame_start_i` is sampled high, and they hold until the next such edge.

Top module: `codec_cmd_seq`

## Requirements
- R1: `codec_rst_no` is low from reset and goes high on the RST_CYCLES-th rising clock edge after `rst_ni` is released. It then stays high.
- R2: The ready state is bit 15 of `rx_tag_i`, taken on each `rx_frame_i` pulse, and is forced to 0 while `codec_rst_no` is low. While it is 0, every frame load gives `zero_frame_o`=1, `cmd_frame_o`=0, and a zero tag and slots.
- R3: The first INIT_LEN frame loads after the codec becomes ready carry the built-in writes. Entry k writes address 2k+2 with data 0x0808+k. `init_done_o` rises on the edge that loads the last entry.
- R4: Every command frame, whether built-in or from the host, has `cmd_frame_o`=1 and tag 0xE000: bit 15 marks a valid frame, bit 14 a valid slot 1 and bit 13 a valid slot 2.
- R5: Slot 1 of a command holds the read flag in bit 19 (1 = read), the 7-bit register address in bits 18:12, and zeros in bits 11:0.
- R6: Slot 2 of a write holds the 16-bit data in bits 19:4 and zeros in bits 3:0. Slot 2 of a read is all zeros.
- R7: A pending host request goes out in the next ready frame load after initialisation, and `wr_done_o` pulses on that edge for a write. A request accepted in the same cycle as `frame_start_i` waits for the following frame. Ready frames with nothing pending give `zero_frame_o`=0, `cmd_frame_o`=0, tag 0x8000 and zero slots.
- R8: A request is accepted when `req_i` is high, initialisation is done and `busy_o` is low. `busy_o` rises on the next edge and falls on the edge of `wr_done_o` or `rd_done_o`.
- R9: A read completes on an `rx_frame_i` pulse whose tag bits 15:13 are all 1 and whose `rx_slot1_i[18:12]` equals the requested address. On that edge `rd_done_o` pulses, `rd_err_o`=0, `rd_addr_o` takes the address and `rd_data_o` takes `rx_slot2_i[19:4]`. All other status frames are ignored.
- R10: If TMO_FRAMES frame loads pass after the read command frame with no match, `rd_done_o` pulses with `rd_err_o`=1, `rd_data_o`=0 and `rd_addr_o` set to the requested address. A match in the same cycle as the last of those frames wins.
- R11: `req_i` has no effect while `busy_o` is high or before `init_done_o` is set.
- R12: A pending request survives a loss of ready. The loads while not ready give zero frames, and the request goes out in the first load after ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame generator asks for the next frame's command fields |
| rx_frame_i | input | 1 | Decoder reports a received frame |
| rx_tag_i | input | 16 | Received tag |
| rx_slot1_i | input | 20 | Received status-address slot |
| rx_slot2_i | input | 20 | Received status-data slot |
| req_i | input | 1 | Host request strobe |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | 7 | Codec register address |
| req_data_i | input | 16 | Write data |
| codec_rst_no | output | 1 | Codec reset, active low |
| zero_frame_o | output | 1 | Frame must be sent as all zeros |
| cmd_frame_o | output | 1 | Frame carries a command |
| tag_o | output | 16 | Outgoing tag |
| slot1_o | output | 20 | Outgoing command-address slot |
| slot2_o | output | 20 | Outgoing command-data slot |
| init_done_o | output | 1 | Built-in write list finished |
| busy_o | output | 1 | A host request is outstanding |
| wr_done_o | output | 1 | Write command sent (pulse) |
| rd_done_o | output | 1 | Read finished (pulse) |
| rd_err_o | output | 1 | Last read timed out |
| rd_addr_o | output | 7 | Address of the finished read |
| rd_data_o | output | 16 | Data of the finished read |

## Verification
Two collisions matter here. The first is a matching status frame arriving in the same cycle as the frame load that would expire the read timeout. The bench provokes it by raising `frame_start_i` and `rx_frame_i` together on the last frame of the window, and it expects a successful completion with no error. The second is a host request accepted in the cycle of a frame load. The bench drives `req_i` and `frame_start_i` together, and it expects a normal audio frame first and the command in the following frame. A behavioural reference model is compared with every output on every clock, so any reordering of these priorities shows up as a mismatch.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;

  localparam logic [TAG_W-1:0] TAG_CMD = 16'hE000;
  localparam logic [TAG_W-1:0] TAG_PCM = 16'h8000;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic [SLOT_W-1:0] slot1_enc(cmd_t c);
    return {c.rd, c.addr, 12'h000};
  endfunction

  function automatic logic [SLOT_W-1:0] slot2_enc(cmd_t c);
    return c.rd ? '0 : {c.data, 4'h0};
  endfunction

  // built-in write list: entry k -> address 2k+2, data 0x0808+k
  function automatic cmd_t init_cmd(int k);
    cmd_t c;
    c.rd   = 1'b0;
    c.addr = ADDR_W'(2 * k + 2);
    c.data = DATA_W'(16'h0808 + k);
    return c;
  endfunction
endpackage

// File: rtl/codec_rst_ctl.sv
module codec_rst_ctl #(
  parameter int RST_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic codec_rst_no
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == CW'(RST_CYCLES - 1)) rel_q <= 1'b1;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign codec_rst_no = rel_q;

  // R1
  rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    codec_rst_no |=> codec_rst_no);
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
  import codec_seq_pkg::*;
#(
  parameter int INIT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output cmd_t cmd_o,
  output logic done_o
);
  localparam int IW = $clog2(INIT_LEN + 1);

  cmd_t          tbl [INIT_LEN];
  logic [IW-1:0] idx_q;
  logic          done_q;

  for (genvar g = 0; g < INIT_LEN; g++) begin : g_tbl
    assign tbl[g] = init_cmd(g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (step_i && !done_q) begin
      if (idx_q == IW'(INIT_LEN - 1)) done_q <= 1'b1;
      else                            idx_q  <= idx_q + 1'b1;
    end
  end

  assign cmd_o  = (int'(idx_q) < INIT_LEN) ? tbl[idx_q] : '0;
  assign done_o = done_q;

  // R3
  init_done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R3
  init_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < INIT_LEN);
endmodule

// File: rtl/codec_req_ctl.sv
module codec_req_ctl
  import codec_seq_pkg::*;
#(
  parameter int TMO_FRAMES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              slot_i,
  input  logic              frame_i,
  input  logic              rx_frame_i,
  input  logic [2:0]        rx_valid_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              go_o,
  output cmd_t              cmd_o,
  output logic              busy_o,
  output logic              wr_done_o,
  output logic              rd_done_o,
  output logic              rd_err_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int TW = $clog2(TMO_FRAMES + 1);

  cmd_t          cmd_q;
  logic          pend_q, busy_q, wait_q;
  logic [TW-1:0] tmo_q;
  logic          accept, match, tmo_hit;

  assign accept  = req_i && en_i && !busy_q;
  assign go_o    = slot_i && pend_q;
  assign match   = wait_q && rx_frame_i && (rx_valid_i == 3'b111) && (rx_addr_i == cmd_q.addr);
  assign tmo_hit = wait_q && !match && frame_i && (tmo_q == TW'(TMO_FRAMES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      pend_q    <= 1'b0;
      busy_q    <= 1'b0;
      wait_q    <= 1'b0;
      tmo_q     <= '0;
      wr_done_o <= 1'b0;
      rd_done_o <= 1'b0;
      rd_err_o  <= 1'b0;
      rd_addr_o <= '0;
      rd_data_o <= '0;
    end else begin
      wr_done_o <= 1'b0;
      rd_done_o <= 1'b0;
      if (accept) begin
        cmd_q  <= '{rd: req_rd_i, addr: req_addr_i, data: req_data_i};
        pend_q <= 1'b1;
        busy_q <= 1'b1;
      end
      if (go_o) begin
        pend_q <= 1'b0;
        if (cmd_q.rd) begin
          wait_q <= 1'b1;
          tmo_q  <= '0;
        end else begin
          busy_q    <= 1'b0;
          wr_done_o <= 1'b1;
        end
      end
      // a reply beats the timeout in the same cycle
      if (match) begin
        rd_done_o <= 1'b1;
        rd_err_o  <= 1'b0;
        rd_addr_o <= rx_addr_i;
        rd_data_o <= rx_data_i;
        wait_q    <= 1'b0;
        busy_q    <= 1'b0;
      end else if (tmo_hit) begin
        rd_done_o <= 1'b1;
        rd_err_o  <= 1'b1;
        rd_addr_o <= cmd_q.addr;
        rd_data_o <= '0;
        wait_q    <= 1'b0;
        busy_q    <= 1'b0;
      end else if (wait_q && frame_i) begin
        tmo_q <= tmo_q + 1'b1;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign busy_o = busy_q;

  // R8
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_done_o, rd_done_o}));
  // R8
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (wr_done_o || rd_done_o));
  // R10
  tmo_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> int'(tmo_q) < TMO_FRAMES);
  // R11
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wr_done_o && !rd_done_o) |=> $stable(cmd_q));
endmodule

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq
  import codec_seq_pkg::*;
#(
  parameter int RST_CYCLES = 100,
  parameter int INIT_LEN   = 4,
  parameter int TMO_FRAMES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              rx_frame_i,
  input  logic [TAG_W-1:0]  rx_tag_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic [SLOT_W-1:0] rx_slot2_i,
  input  logic              req_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              codec_rst_no,
  output logic              zero_frame_o,
  output logic              cmd_frame_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [SLOT_W-1:0] slot1_o,
  output logic [SLOT_W-1:0] slot2_o,
  output logic              init_done_o,
  output logic              busy_o,
  output logic              wr_done_o,
  output logic              rd_done_o,
  output logic              rd_err_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic ready_q, init_done, init_step, req_slot, req_go;
  cmd_t init_c, req_c;
  logic unused_rx;

  assign unused_rx = ^{rx_tag_i[12:0], rx_slot1_i[19], rx_slot1_i[11:0], rx_slot2_i[3:0]};

  codec_rst_ctl #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .codec_rst_no(codec_rst_no));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ready_q <= 1'b0;
    else if (!codec_rst_no) ready_q <= 1'b0;
    else if (rx_frame_i)    ready_q <= rx_tag_i[15];
  end

  assign init_step = frame_start_i && ready_q && !init_done;
  assign req_slot  = frame_start_i && ready_q && init_done;

  codec_init_seq #(.INIT_LEN(INIT_LEN)) u_init (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(init_step),
    .cmd_o(init_c), .done_o(init_done));

  codec_req_ctl #(.TMO_FRAMES(TMO_FRAMES)) u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(init_done),
    .req_i(req_i), .req_rd_i(req_rd_i), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
    .slot_i(req_slot), .frame_i(frame_start_i),
    .rx_frame_i(rx_frame_i), .rx_valid_i(rx_tag_i[15:13]),
    .rx_addr_i(rx_slot1_i[18:12]), .rx_data_i(rx_slot2_i[19:4]),
    .go_o(req_go), .cmd_o(req_c), .busy_o(busy_o),
    .wr_done_o(wr_done_o), .rd_done_o(rd_done_o), .rd_err_o(rd_err_o),
    .rd_addr_o(rd_addr_o), .rd_data_o(rd_data_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_frame_o <= 1'b1;
      cmd_frame_o  <= 1'b0;
      tag_o        <= '0;
      slot1_o      <= '0;
      slot2_o      <= '0;
    end else if (frame_start_i) begin
      if (!ready_q) begin
        zero_frame_o <= 1'b1;
        cmd_frame_o  <= 1'b0;
        tag_o        <= '0;
        slot1_o      <= '0;
        slot2_o      <= '0;
      end else if (!init_done || req_go) begin
        zero_frame_o <= 1'b0;
        cmd_frame_o  <= 1'b1;
        tag_o        <= TAG_CMD;
        slot1_o      <= slot1_enc(init_done ? req_c : init_c);
        slot2_o      <= slot2_enc(init_done ? req_c : init_c);
      end else begin
        zero_frame_o <= 1'b0;
        cmd_frame_o  <= 1'b0;
        tag_o        <= TAG_PCM;
        slot1_o      <= '0;
        slot2_o      <= '0;
      end
    end
  end

  assign init_done_o = init_done;

  // R2
  not_ready_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && !ready_q) |=> (zero_frame_o && tag_o == '0));
  // R2
  ready_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !codec_rst_no |=> !ready_q);
  // R4
  cmd_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_go || init_step) |=> (cmd_frame_o && tag_o == TAG_CMD));
  // R7
  wr_sent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> (cmd_frame_o && !slot1_o[19]));
endmodule

// File: tb/sim_codec_cmd_seq.sv
module sim_codec_cmd_seq;
  localparam int RST = 20;
  localparam int INIT = 3;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, rx_frame = 0, req = 0, req_rd = 0;
  logic [15:0] rx_tag = 0;
  logic [19:0] rx_s1 = 0, rx_s2 = 0;
  logic [6:0]  req_addr = 0;
  logic [15:0] req_data = 0;

  logic        crst, zero_f, cmd_f, idone, busy, wrd, rdd, rerr;
  logic [15:0] tag, rdata;
  logic [19:0] s1, s2;
  logic [6:0]  raddr;

  always #4 clk = ~clk;

  codec_cmd_seq #(.RST_CYCLES(RST), .INIT_LEN(INIT), .TMO_FRAMES(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .rx_frame_i(rx_frame),
    .rx_tag_i(rx_tag), .rx_slot1_i(rx_s1), .rx_slot2_i(rx_s2),
    .req_i(req), .req_rd_i(req_rd), .req_addr_i(req_addr), .req_data_i(req_data),
    .codec_rst_no(crst), .zero_frame_o(zero_f), .cmd_frame_o(cmd_f), .tag_o(tag),
    .slot1_o(s1), .slot2_o(s2), .init_done_o(idone), .busy_o(busy),
    .wr_done_o(wrd), .rd_done_o(rdd), .rd_err_o(rerr), .rd_addr_o(raddr), .rd_data_o(rdata));

  int total = 0, bad = 0, cyc = 0;

  // reference model state
  bit m_crst = 0, m_ready = 0, m_idone = 0, m_pend = 0, m_busy = 0, m_wait = 0;
  int m_cnt = 0, m_ik = 0, m_tmo = 0;
  bit m_zero = 1, m_cmdf = 0, m_wrd = 0, m_rdd = 0, m_rerr = 0;
  bit [15:0] m_tag = 0, m_rdata = 0;
  bit [19:0] m_s1 = 0, m_s2 = 0;
  bit [6:0]  m_raddr = 0;
  string     m_kind = "R2";
  bit q_rd = 0; bit [6:0] q_addr = 0; bit [15:0] q_data = 0;

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", r, $time, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_crst = 0; m_cnt = 0; m_ready = 0; m_idone = 0; m_ik = 0; m_pend = 0;
      m_busy = 0; m_wait = 0; m_tmo = 0; m_zero = 1; m_cmdf = 0; m_tag = 0;
      m_s1 = 0; m_s2 = 0; m_wrd = 0; m_rdd = 0; m_rerr = 0; m_raddr = 0; m_rdata = 0;
      m_kind = "R2";
    end else begin
      bit o_crst, o_ready, o_idone, o_pend, o_busy, o_wait; int o_tmo; bit hit;
      o_crst = m_crst; o_ready = m_ready; o_idone = m_idone; o_pend = m_pend;
      o_busy = m_busy; o_wait = m_wait; o_tmo = m_tmo;
      m_wrd = 0; m_rdd = 0;
      if (!o_crst) begin m_cnt++; if (m_cnt == RST) m_crst = 1; end
      if (!o_crst) m_ready = 0; else if (rx_frame) m_ready = rx_tag[15];
      if (frame_start) begin
        if (!o_ready) begin
          m_kind = "R2"; m_zero = 1; m_cmdf = 0; m_tag = 0; m_s1 = 0; m_s2 = 0;
        end else if (!o_idone) begin
          m_kind = "R3"; m_zero = 0; m_cmdf = 1; m_tag = 16'hE000;
          m_s1 = {1'b0, 7'(2 * m_ik + 2), 12'h0};
          m_s2 = {16'(16'h0808 + m_ik), 4'h0};
          m_ik++; if (m_ik == INIT) m_idone = 1;
        end else if (o_pend) begin
          m_kind = "R5"; m_zero = 0; m_cmdf = 1; m_tag = 16'hE000;
          m_s1 = {q_rd, q_addr, 12'h0};
          m_s2 = q_rd ? 20'h0 : {q_data, 4'h0};
          m_pend = 0;
          if (q_rd) begin m_wait = 1; m_tmo = 0; end
          else begin m_busy = 0; m_wrd = 1; end
        end else begin
          m_kind = "R7"; m_zero = 0; m_cmdf = 0; m_tag = 16'h8000; m_s1 = 0; m_s2 = 0;
        end
      end
      if (req && !o_busy && o_idone) begin
        q_rd = req_rd; q_addr = req_addr; q_data = req_data; m_pend = 1; m_busy = 1;
      end
      if (o_wait) begin
        hit = rx_frame && rx_tag[15:13] == 3'b111 && rx_s1[18:12] == q_addr;
        if (hit) begin
          m_rdd = 1; m_rerr = 0; m_raddr = q_addr; m_rdata = rx_s2[19:4]; m_wait = 0; m_busy = 0;
        end else if (frame_start) begin
          if (o_tmo == TMO - 1) begin
            m_rdd = 1; m_rerr = 1; m_raddr = q_addr; m_rdata = 0; m_wait = 0; m_busy = 0;
          end else m_tmo = o_tmo + 1;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(crst === m_crst, "R1 codec_rst_no", crst, m_crst);
    chk(zero_f === m_zero, {m_kind, " zero_frame"}, zero_f, m_zero);
    chk(cmd_f === m_cmdf, {m_kind, " cmd_frame"}, cmd_f, m_cmdf);
    chk(tag === m_tag, (m_cmdf ? "R4 tag" : {m_kind, " tag"}), tag, m_tag);
    chk(s1 === m_s1, (m_kind == "R5" ? "R5 slot1" : {m_kind, " slot1"}), s1, m_s1);
    chk(s2 === m_s2, (m_kind == "R5" ? "R6 slot2" : {m_kind, " slot2"}), s2, m_s2);
    chk(idone === m_idone, "R3 init_done", idone, m_idone);
    chk(busy === m_busy, "R8 busy", busy, m_busy);
    chk(wrd === m_wrd, "R7 wr_done", wrd, m_wrd);
    chk(rdd === m_rdd, "R9 rd_done", rdd, m_rdd);
    if (m_rdd) begin
      chk(rerr === m_rerr, "R10 rd_err", rerr, m_rerr);
      chk(raddr === m_raddr, "R9 rd_addr", raddr, m_raddr);
      chk(rdata === m_rdata, "R9 rd_data", rdata, m_rdata);
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic frame();
    frame_start = 1; tick(1); frame_start = 0; tick(2);
  endtask
  task automatic rx(logic [15:0] t, logic [19:0] a, logic [19:0] d);
    rx_frame = 1; rx_tag = t; rx_s1 = a; rx_s2 = d; tick(1); rx_frame = 0;
  endtask
  task automatic request(logic rd, logic [6:0] a, logic [15:0] d);
    req = 1; req_rd = rd; req_addr = a; req_data = d; tick(1); req = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    rx(16'h8000, 0, 0);             // R2: ready ignored while codec held in reset
    tick(RST + 2);
    chk(crst === 1'b1, "R1 release", crst, 1);
    frame();
    chk(zero_f === 1'b1, "R2 zero before ready", zero_f, 1);
    rx(16'h0000, 0, 0);
    frame();
    request(0, 7'h40, 16'h5555);    // R11: before init, ignored
    tick(1);
    chk(busy === 1'b0, "R11 req before init", busy, 0);
    rx(16'h8000, 0, 0);
    for (int i = 0; i < INIT; i++) frame();
    chk(idone === 1'b1, "R3 init finished", idone, 1);
    frame();
    chk(tag === 16'h8000 && cmd_f === 1'b0, "R7 pcm frame", tag, 16'h8000);
    // write
    request(0, 7'h2A, 16'hBEEF);
    frame();
    chk(s2 === {16'hBEEF, 4'h0}, "R6 write data", s2, {16'hBEEF, 4'h0});
    // read with non-matching replies first
    request(1, 7'h26, 16'hFFFF);
    frame();
    chk(s1 === {1'b1, 7'h26, 12'h0} && s2 === 0, "R5 read slots", s1, {1'b1, 7'h26, 12'h0});
    rx(16'hE000, {1'b0, 7'h10, 12'h0}, {16'h9999, 4'h0});
    rx(16'h8000, {1'b0, 7'h26, 12'h0}, {16'h7777, 4'h0});
    frame();
    chk(busy === 1'b1, "R9 wrong status ignored", busy, 1);
    rx(16'hE000, {1'b0, 7'h26, 12'h0}, {16'h1234, 4'h0});
    tick(1);
    chk(rdata === 16'h1234 && rerr === 1'b0, "R9 read data", rdata, 16'h1234);
    // read timeout
    request(1, 7'h30, 0);
    frame();
    for (int i = 0; i < TMO; i++) frame();
    chk(rerr === 1'b1 && busy === 1'b0, "R10 timeout", rerr, 1);
    // reply collides with last timeout frame
    request(1, 7'h18, 0);
    frame();
    for (int i = 0; i < TMO - 1; i++) frame();
    frame_start = 1; rx(16'hE000, {1'b0, 7'h18, 12'h0}, {16'hA5A5, 4'h0}); frame_start = 0;
    tick(1);
    chk(rerr === 1'b0 && rdata === 16'hA5A5, "R10 reply wins", rdata, 16'hA5A5);
    // accept in a frame cycle
    frame_start = 1; request(0, 7'h0C, 16'h0102); frame_start = 0;
    tick(1);
    chk(cmd_f === 1'b0, "R7 same-cycle accept waits", cmd_f, 0);
    frame();
    chk(s1 === {1'b0, 7'h0C, 12'h0}, "R7 next frame cmd", s1, {1'b0, 7'h0C, 12'h0});
    // ready drops with request pending
    request(0, 7'h1E, 16'h3C3C);
    rx(16'h0000, 0, 0);
    frame();
    chk(zero_f === 1'b1 && busy === 1'b1, "R12 held while not ready", zero_f, 1);
    rx(16'h8000, 0, 0);
    frame();
    chk(s1 === {1'b0, 7'h1E, 12'h0}, "R12 sent after ready", s1, {1'b0, 7'h1E, 12'h0});
    // request while busy
    request(0, 7'h11, 16'h0001);
    request(0, 7'h22, 16'h0002);
    frame();
    chk(s1 === {1'b0, 7'h11, 12'h0}, "R11 busy req ignored", s1, {1'b0, 7'h11, 12'h0});
    frame();
    chk(cmd_f === 1'b0, "R11 no second cmd", cmd_f, 0);
    tick(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule